// File: doc/BRIEF.md
# SUBLEQ One-Instruction Processor Core

This block is a small processor whose only operation is "subtract and branch if the result is less than or equal to zero". It keeps its program in one memory and its operands in another. Each memory has its own loading port on its own clock, and each port can write a location and read a location back. A third clock drives execution. The core runs only while its activate input is held high, and it reports its state, its program counter and the outcome of the most recent comparison.

Each instruction word names two operand cells, A and B, and a branch target C. Executing it subtracts the value at A from the value at B and stores the difference at B. The program counter moves to C when the signed difference is zero or negative, and to the next address otherwise. Software builds everything else from this step. Clearing a cell by subtracting it from itself, with A equal to B, always branches, so it serves as an unconditional jump. A self-jump at the last program address serves as a halt. An addition of X into Y uses a zero cell Z in three steps: Z minus X, then Y minus Z, then Z minus Z.

The loading ports are expected to be idle while the core runs. The activate request crosses into the core clock domain through a two-stage synchroniser.

Top module: `subleq_core`

## Requirements
- R1: An instruction word is {A, B, C} with A in the most significant DADDR_BITS bits, B in the next DADDR_BITS bits and C in the low PC_BITS bits. With the defaults (8, 4, 8) this gives A = word[15:12], B = word[11:8] and C = word[7:0].
- R2: Executing an instruction writes (mem[B] - mem[A]) mod 2^DATA_BITS to data cell B. Cell A keeps its value unless A equals B.
- R3: After an instruction the program counter becomes C when the stored difference, read as two's complement, is zero or negative (its sign bit is set or it is all zeros). Otherwise the program counter becomes PC+1.
- R4: leq_flag is 1 exactly when the most recently completed instruction branched. It changes on the same core clock edge as pc.
- R5: While core_clr is high and on the edge after it, pc = 0, running = 0 and leq_flag = 0. After a clear the core executes nothing and pc stays 0 until activate is seen.
- R6: From the edge on which running rises, the core fetches from the held pc (0 after a clear). Each instruction takes exactly 4 core cycles, so pc first changes 4 edges after running rises and then every 4 edges.
- R7: When run_req falls, the instruction in progress completes. The core then goes idle, with running = 0 and pc and data held. A later rise of run_req resumes from the held pc.
- R8: A program port write stores prog_wdata at prog_addr on a clk_prog edge. prog_rdata shows the word at prog_addr one clk_prog edge later.
- R9: A data port write stores data_wdata at data_addr on a clk_data edge. data_rdata shows the cell at data_addr one clk_data edge later, including values the core wrote after the port's last write to that cell.
- R10: An instruction with A = B pointing at a zero cell and C equal to its own address holds pc at that address indefinitely and leaves the zero cell at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_prog | input | 1 | Program loading port clock |
| prog_we | input | 1 | Program memory write enable |
| prog_addr | input | PC_BITS | Program memory address for write and read-back |
| prog_wdata | input | 2*DADDR_BITS+PC_BITS | Instruction word to store |
| prog_rdata | output | 2*DADDR_BITS+PC_BITS | Registered read-back of the program memory |
| clk_data | input | 1 | Data loading port clock |
| data_we | input | 1 | Data memory write enable |
| data_addr | input | DADDR_BITS | Data memory address for write and read-back |
| data_wdata | input | DATA_BITS | Data word to store |
| data_rdata | output | DATA_BITS | Registered read-back of the data memory |
| clk_core | input | 1 | Execution clock |
| core_clr | input | 1 | Synchronous active-high clear of the core |
| run_req | input | 1 | Activate request, may be asynchronous to clk_core |
| running | output | 1 | High while the core is executing |
| pc | output | PC_BITS | Current program counter |
| leq_flag | output | 1 | Outcome of the most recent comparison |

## Verification
A wrong operand fetch or subtraction is invisible to pc alone when the branch happens to go the same way. It shows up when the data port reads back cell B after the core stops, so every sweep vector reads back both operand cells. A wrong branch decision or wrong flag appears on pc and leq_flag at the very edge the instruction completes: a swapped target sends pc to 1 instead of 10 in the sweep program. A sequencing fault, such as a lost or extra state, shows within one instruction as a change in the 4-cycle spacing of pc updates. It also shows as a different intermediate value of the zero cell when run_req is dropped mid-program.

// File: rtl/subleq_pkg.sv
package subleq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_OPA   = 3'd2,
    ST_OPB   = 3'd3,
    ST_EXEC  = 3'd4
  } core_state_t;

endpackage

// File: rtl/subleq_sync.sv
module subleq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/subleq_prog_mem.sv
module subleq_prog_mem #(
  parameter int AW = 8,
  parameter int WW = 16
) (
  input  logic          ld_clk,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [WW-1:0] ld_wdata,
  output logic [WW-1:0] ld_rdata,
  input  logic          cr_clk,
  input  logic [AW-1:0] cr_addr,
  output logic [WW-1:0] cr_rdata
);

  localparam int DEPTH = 1 << AW;

  logic [WW-1:0] mem [DEPTH];

  // loading port: write plus registered read-back
  always_ff @(posedge ld_clk) begin
    if (ld_we) mem[ld_addr] <= ld_wdata;
    ld_rdata <= mem[ld_addr];
  end

  // core fetch port: registered read
  always_ff @(posedge cr_clk) begin
    cr_rdata <= mem[cr_addr];
  end

endmodule

// File: rtl/subleq_data_mem.sv
// Two-writer memory built from one bank per writer and a live-value table:
// each cell remembers which bank holds its newest value.
module subleq_data_mem #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          x_clk,
  input  logic          x_we,
  input  logic [AW-1:0] x_addr,
  input  logic [DW-1:0] x_wdata,
  output logic [DW-1:0] x_rdata,
  input  logic          y_clk,
  input  logic          y_rst,
  input  logic          y_we,
  input  logic [AW-1:0] y_addr,
  input  logic [DW-1:0] y_wdata,
  output logic [DW-1:0] y_rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    bank_x [DEPTH];
  logic [DW-1:0]    bank_y [DEPTH];
  logic [DEPTH-1:0] lvt_x;
  logic [DEPTH-1:0] lvt_y;

  // lvt_x ^ lvt_y == 1 selects bank_x for that cell
  always_ff @(posedge x_clk) begin
    if (x_we) begin
      bank_x[x_addr] <= x_wdata;
      lvt_x[x_addr]  <= ~lvt_y[x_addr];
    end
    x_rdata <= (lvt_x[x_addr] ^ lvt_y[x_addr]) ? bank_x[x_addr] : bank_y[x_addr];
  end

  always_ff @(posedge y_clk) begin
    if (y_we) begin
      bank_y[y_addr] <= y_wdata;
      lvt_y[y_addr]  <= lvt_x[y_addr];
    end
    y_rdata <= (lvt_x[y_addr] ^ lvt_y[y_addr]) ? bank_x[y_addr] : bank_y[y_addr];
  end

  // R9: after a core write the table points that cell at the core bank
  assert_core_newest_R9: assert property (@(posedge y_clk) disable iff (y_rst)
    y_we |=> (lvt_x[$past(y_addr)] == lvt_y[$past(y_addr)]));

endmodule

// File: rtl/subleq_ctrl.sv
module subleq_ctrl
  import subleq_pkg::*;
#(
  parameter int PAW = 8,
  parameter int DAW = 4,
  parameter int DW  = 8
) (
  input  logic                   clk,
  input  logic                   clr,
  input  logic                   go,
  output logic [PAW-1:0]         fetch_addr,
  input  logic [2*DAW+PAW-1:0]   fetch_word,
  output logic                   dat_we,
  output logic [DAW-1:0]         dat_addr,
  output logic [DW-1:0]          dat_wdata,
  input  logic [DW-1:0]          dat_rdata,
  output logic                   running,
  output logic [PAW-1:0]         pc,
  output logic                   leq_flag
);

  localparam int IW = 2*DAW + PAW;

  core_state_t    state_q;
  logic [DAW-1:0] ir_b_q;
  logic [PAW-1:0] ir_c_q;
  logic [DW-1:0]  opa_q;
  logic [PAW-1:0] pc_q;
  logic           leq_q;
  logic           running_q;

  logic [DAW-1:0] word_a;
  logic [DAW-1:0] word_b;
  logic [PAW-1:0] word_c;
  logic [DW-1:0]  diff;
  logic           le_zero;

  assign word_a  = fetch_word[IW-1 -: DAW];
  assign word_b  = fetch_word[PAW +: DAW];
  assign word_c  = fetch_word[PAW-1:0];

  assign diff    = dat_rdata - opa_q;
  assign le_zero = diff[DW-1] | (diff == '0);

  assign fetch_addr = pc_q;
  assign dat_addr   = (state_q == ST_OPA) ? word_a : ir_b_q;
  assign dat_we     = (state_q == ST_EXEC);
  assign dat_wdata  = diff;

  always_ff @(posedge clk) begin
    if (clr) begin
      state_q   <= ST_IDLE;
      ir_b_q    <= '0;
      ir_c_q    <= '0;
      opa_q     <= '0;
      pc_q      <= '0;
      leq_q     <= 1'b0;
      running_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (go) begin
            state_q   <= ST_FETCH;
            running_q <= 1'b1;
          end
        end
        ST_FETCH: state_q <= ST_OPA;
        ST_OPA: begin
          ir_b_q  <= word_b;
          ir_c_q  <= word_c;
          state_q <= ST_OPB;
        end
        ST_OPB: begin
          opa_q   <= dat_rdata;
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          pc_q      <= le_zero ? ir_c_q : pc_q + 1'b1;
          leq_q     <= le_zero;
          state_q   <= go ? ST_FETCH : ST_IDLE;
          running_q <= go;
        end
        default: begin
          state_q   <= ST_IDLE;
          running_q <= 1'b0;
        end
      endcase
    end
  end

  assign running  = running_q;
  assign pc       = pc_q;
  assign leq_flag = leq_q;

  // R5: clear leaves the core idle at address 0
  assert_clear_state_R5: assert property (@(posedge clk)
    clr |=> (pc_q == '0 && !running_q && !leq_q));

  // R5: no activity without the synchronised request
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (clr)
    (state_q == ST_IDLE && !go) |=> (state_q == ST_IDLE && !running_q));

  // R7: pc only moves on instruction completion
  assert_pc_hold_R7: assert property (@(posedge clk) disable iff (clr)
    (state_q != ST_EXEC) |=> $stable(pc_q));

  // R3: branch target taken exactly when the flag is set
  assert_branch_R3: assert property (@(posedge clk) disable iff (clr)
    (state_q == ST_EXEC) |=>
      (leq_q ? (pc_q == $past(ir_c_q)) : (pc_q == $past(pc_q) + 1'b1)));

endmodule

// File: rtl/subleq_core.sv
module subleq_core #(
  parameter int PC_BITS     = 8,
  parameter int DADDR_BITS  = 4,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                              clk_prog,
  input  logic                              prog_we,
  input  logic [PC_BITS-1:0]                prog_addr,
  input  logic [2*DADDR_BITS+PC_BITS-1:0]   prog_wdata,
  output logic [2*DADDR_BITS+PC_BITS-1:0]   prog_rdata,
  input  logic                              clk_data,
  input  logic                              data_we,
  input  logic [DADDR_BITS-1:0]             data_addr,
  input  logic [DATA_BITS-1:0]              data_wdata,
  output logic [DATA_BITS-1:0]              data_rdata,
  input  logic                              clk_core,
  input  logic                              core_clr,
  input  logic                              run_req,
  output logic                              running,
  output logic [PC_BITS-1:0]                pc,
  output logic                              leq_flag
);

  localparam int INSTR_BITS = 2*DADDR_BITS + PC_BITS;

  logic                   go_sync;
  logic [PC_BITS-1:0]     fetch_addr;
  logic [INSTR_BITS-1:0]  fetch_word;
  logic                   core_we;
  logic [DADDR_BITS-1:0]  core_addr;
  logic [DATA_BITS-1:0]   core_wdata;
  logic [DATA_BITS-1:0]   core_rdata;

  subleq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk_core),
    .rst (core_clr),
    .d   (run_req),
    .q   (go_sync)
  );

  subleq_prog_mem #(.AW(PC_BITS), .WW(INSTR_BITS)) u_prog (
    .ld_clk   (clk_prog),
    .ld_we    (prog_we),
    .ld_addr  (prog_addr),
    .ld_wdata (prog_wdata),
    .ld_rdata (prog_rdata),
    .cr_clk   (clk_core),
    .cr_addr  (fetch_addr),
    .cr_rdata (fetch_word)
  );

  subleq_data_mem #(.AW(DADDR_BITS), .DW(DATA_BITS)) u_data (
    .x_clk   (clk_data),
    .x_we    (data_we),
    .x_addr  (data_addr),
    .x_wdata (data_wdata),
    .x_rdata (data_rdata),
    .y_clk   (clk_core),
    .y_rst   (core_clr),
    .y_we    (core_we),
    .y_addr  (core_addr),
    .y_wdata (core_wdata),
    .y_rdata (core_rdata)
  );

  subleq_ctrl #(.PAW(PC_BITS), .DAW(DADDR_BITS), .DW(DATA_BITS)) u_ctrl (
    .clk        (clk_core),
    .clr        (core_clr),
    .go         (go_sync),
    .fetch_addr (fetch_addr),
    .fetch_word (fetch_word),
    .dat_we     (core_we),
    .dat_addr   (core_addr),
    .dat_wdata  (core_wdata),
    .dat_rdata  (core_rdata),
    .running    (running),
    .pc         (pc),
    .leq_flag   (leq_flag)
  );

endmodule

// File: tb/sim_subleq_core.sv
`timescale 1ns/1ps
module sim_subleq_core;

  logic        clk_prog = 1'b0;
  logic        prog_we = 1'b0;
  logic [7:0]  prog_addr = '0;
  logic [15:0] prog_wdata = '0;
  logic [15:0] prog_rdata;
  logic        clk_data = 1'b0;
  logic        data_we = 1'b0;
  logic [3:0]  data_addr = '0;
  logic [7:0]  data_wdata = '0;
  logic [7:0]  data_rdata;
  logic        clk_core = 1'b0;
  logic        core_clr = 1'b1;
  logic        run_req = 1'b0;
  logic        running;
  logic [7:0]  pc;
  logic        leq_flag;

  int nvec = 0;
  int nerr = 0;

  always #10 clk_core = ~clk_core;  // 50 MHz
  always #7  clk_data = ~clk_data;
  always #13 clk_prog = ~clk_prog;

  subleq_core u0 (
    .clk_prog(clk_prog), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_wdata(prog_wdata), .prog_rdata(prog_rdata),
    .clk_data(clk_data), .data_we(data_we), .data_addr(data_addr),
    .data_wdata(data_wdata), .data_rdata(data_rdata),
    .clk_core(clk_core), .core_clr(core_clr), .run_req(run_req),
    .running(running), .pc(pc), .leq_flag(leq_flag)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_core);
    nerr++;
    $display("FAIL R6 watchdog actual=%0d expected=%0d", 150000, 0);
    summary();
    $finish;
  end

  // R1 field layout: {A[3:0], B[3:0], C[7:0]}
  function automatic logic [15:0] enc(input int a, input int b, input int c);
    enc = {a[3:0], b[3:0], c[7:0]};
  endfunction

  task automatic prog_write(input int addr, input logic [15:0] w);
    @(negedge clk_prog);
    prog_we = 1'b1; prog_addr = addr[7:0]; prog_wdata = w;
    @(negedge clk_prog);
    prog_we = 1'b0;
  endtask

  task automatic prog_read(input int addr, output logic [15:0] w);
    @(negedge clk_prog);
    prog_we = 1'b0; prog_addr = addr[7:0];
    @(posedge clk_prog);
    @(negedge clk_prog);
    w = prog_rdata;
  endtask

  task automatic data_write(input int addr, input logic [7:0] v);
    @(negedge clk_data);
    data_we = 1'b1; data_addr = addr[3:0]; data_wdata = v;
    @(negedge clk_data);
    data_we = 1'b0;
  endtask

  task automatic data_read(input int addr, output logic [7:0] v);
    @(negedge clk_data);
    data_we = 1'b0; data_addr = addr[3:0];
    @(posedge clk_data);
    @(negedge clk_data);
    v = data_rdata;
  endtask

  task automatic core_clear();
    @(negedge clk_core);
    core_clr = 1'b1;
    repeat (2) @(negedge clk_core);
    core_clr = 1'b0;
  endtask

  task automatic wait_running(input logic lvl, output int n);
    n = 0;
    do begin
      @(negedge clk_core);
      n++;
    end while (running != lvl && n < 200);
  endtask

  task automatic wait_pc_move(input logic [7:0] from, output int n);
    n = 0;
    do begin
      @(negedge clk_core);
      n++;
    end while (pc == from && n < 200);
  endtask

  task automatic load_add_prog();
    prog_write(0,   enc(0, 0, 8));
    prog_write(8,   enc(1, 0, 9));
    prog_write(9,   enc(0, 2, 10));
    prog_write(10,  enc(0, 0, 11));
    prog_write(11,  enc(0, 0, 255));
    prog_write(255, enc(0, 0, 255));
  endtask

  task automatic run_add(input logic [7:0] x, input logic [7:0] y, input bit stop_mid);
    int n;
    logic [7:0] v;
    data_write(0, 8'd0);
    data_write(1, x);
    data_write(2, y);
    core_clear();
    @(negedge clk_core);
    run_req = 1'b1;
    wait_running(1'b1, n);
    chk(running == 1'b1, "R6", int'(running), 1);
    wait_pc_move(8'd0, n);
    chk(n == 4, "R6", n, 4);
    chk(pc == 8'd8, "R6", int'(pc), 8);
    if (stop_mid) begin
      run_req = 1'b0;
      wait_running(1'b0, n);
      chk(pc == 8'd9, "R7", int'(pc), 9);
      repeat (10) @(negedge clk_core);
      chk(pc == 8'd9 && !running, "R7", int'(pc), 9);
      data_read(0, v);
      chk(v == 8'(0 - x), "R7", int'(v), int'(8'(0 - x)));
      @(negedge clk_core);
      run_req = 1'b1;
    end else begin
      wait_pc_move(8'd8, n);
      chk(n == 4 && pc == 8'd9, "R6", n, 4);
    end
    n = 0;
    while (pc != 8'd255 && n < 200) begin
      @(negedge clk_core);
      n++;
    end
    repeat (20) @(negedge clk_core);
    chk(pc == 8'd255 && running, "R10", int'(pc), 255);
    run_req = 1'b0;
    wait_running(1'b0, n);
    chk(!running && pc == 8'd255, "R7", int'(running), 0);
    data_read(2, v);
    chk(v == 8'(x + y), "R1", int'(v), int'(8'(x + y)));
    data_read(0, v);
    chk(v == 8'd0, "R10", int'(v), 0);
    data_read(1, v);
    chk(v == x, "R2", int'(v), int'(x));
  endtask

  task automatic run_sub(input logic [7:0] a, input logic [7:0] b);
    int n;
    logic [7:0] res;
    logic le;
    logic [7:0] v;
    res = b - a;
    le  = res[7] | (res == 8'd0);
    data_write(0, 8'd0);
    data_write(1, a);
    data_write(2, b);
    core_clear();
    @(negedge clk_core);
    run_req = 1'b1;
    wait_pc_move(8'd0, n);
    chk(pc == (le ? 8'd10 : 8'd1), "R3", int'(pc), le ? 10 : 1);
    chk(leq_flag == le, "R4", int'(leq_flag), int'(le));
    repeat (12) @(negedge clk_core);
    run_req = 1'b0;
    wait_running(1'b0, n);
    data_read(2, v);
    chk(v == res, "R2", int'(v), int'(res));
    data_read(1, v);
    chk(v == a, "R2", int'(v), int'(a));
  endtask

  initial begin
    logic [15:0] w;
    logic [7:0]  v;
    repeat (4) @(negedge clk_core);
    // R5 reset state during clear
    chk(pc == 8'd0 && !running && !leq_flag, "R5", int'(pc), 0);
    core_clr = 1'b0;

    // R8 program load and read-back
    load_add_prog();
    prog_read(0, w);
    chk(w == enc(0, 0, 8), "R8", int'(w), int'(enc(0, 0, 8)));
    prog_read(8, w);
    chk(w == enc(1, 0, 9), "R8", int'(w), int'(enc(1, 0, 9)));
    prog_read(255, w);
    chk(w == enc(0, 0, 255), "R8", int'(w), int'(enc(0, 0, 255)));

    // R9 data port write and read-back
    data_write(5, 8'hA5);
    data_read(5, v);
    chk(v == 8'hA5, "R9", int'(v), 165);

    // R5 idle with no request
    repeat (20) @(negedge clk_core);
    chk(pc == 8'd0 && !running, "R5", int'(pc), 0);

    // addition program, plain and stopped midway
    run_add(8'd12, 8'd34, 1'b0);
    run_add(8'd200, 8'd100, 1'b0);
    run_add(8'd0, 8'd255, 1'b0);
    run_add(8'd12, 8'd34, 1'b1);
    run_add(8'd128, 8'd127, 1'b1);

    // sweep program: subtract cell 1 from cell 2, branch to 10 on <= 0
    prog_write(0,  enc(1, 2, 10));
    prog_write(1,  enc(0, 0, 1));
    prog_write(10, enc(0, 0, 10));
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        run_sub(8'(i * 17), 8'(j * 17));
      end
    end
    run_sub(8'h01, 8'h80);
    run_sub(8'hFF, 8'h7F);
    run_sub(8'h80, 8'h00);
    run_sub(8'h7F, 8'hFF);
    run_sub(8'h01, 8'h02);
    run_sub(8'h02, 8'h01);

    summary();
    $finish;
  end

endmodule